// File: doc/BRIEF.md
# Row-Hopping DRAM Read Sequencer

This block produces a stream of single-word read requests meant to stress a DRAM controller. It deliberately defeats open-page locality. The bank index moves fastest, then the row, then the column. As a result, two reads in a row never target the same open row, and the controller must precharge and activate before nearly every access.

A run is started with a one-cycle `start` pulse. Each request is offered on a valid/ready handshake as separate bank, row and column fields, and also as one packed linear address. Only one read is in flight at a time. The block waits for the response before it offers the next address.

When compare is enabled for the run, each returned word is checked against the value on `exp_data`. The first mismatch stops the run and records where it happened. A run that completes cleanly ends with a one-cycle `done` pulse, after which the block is idle again.

Top module: `rowhop_rd_seq`

## Requirements
- R1: After reset, `rd_valid`, `busy`, `done` and `fail` are low and `rd_count` is 0.
- R2: Read number k (counting from 0) of a run targets bank = k mod NUM_BANKS, row = (k / NUM_BANKS) mod NUM_ROWS, and column = k / (NUM_BANKS*NUM_ROWS).
- R3: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and the address stays unchanged. The address advances only on a cycle with both `rd_valid` and `rd_ready` high.
- R4: `rd_addr` is packed as {row, bank, column}, with the column in the least significant bits. Bank and column take ceil(log2) of their counts in bits, with a minimum of 1 bit.
- R5: At most one read is outstanding. After a handshake, `rd_valid` stays low until `rsp_valid` has returned that read's data.
- R6: `rd_count` is cleared by an accepted `start` and increments by one for every response received.
- R7: The cycle after the response to the last read, `done` is high for exactly one cycle and `busy` is low.
- R8: With compare enabled, a response whose data differs from `exp_data` has these effects:
  - it sets `fail`;
  - it latches that read's bank, row and column into the `fail_*` outputs;
  - it ends the run, so `busy` goes low and no `done` pulse is issued;
  - it is still counted in `rd_count`.
- R9: The compare enable is sampled at `start`. In a run started with it low, response data is ignored and `fail` stays low.
- R10: When NUM_BANKS*NUM_ROWS > 1, every read targets a different (bank, row) pair than the read accepted just before it in the same run.
- R11: A `start` pulse while busy is ignored, and the address sequence continues. A `start` from idle clears `fail` and begins again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| cmp_en | input | 1 | Enable data compare for the run being started |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_bank | output | BANK_W | Bank of the offered read |
| rd_row | output | ROW_W | Row of the offered read |
| rd_col | output | COL_W | Column of the offered read |
| rd_addr | output | ADDR_W | Packed {row, bank, column} address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | DATA_W | Returned read data |
| exp_data | input | DATA_W | Expected value for the returned data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse on clean completion |
| rd_count | output | CNT_W | Responses received in the current run |
| fail | output | 1 | A compare mismatch stopped the run |
| fail_bank | output | BANK_W | Bank of the failing read |
| fail_row | output | ROW_W | Row of the failing read |
| fail_col | output | COL_W | Column of the failing read |

## Verification
The bench walks every address of a 2-bank, 4-row, 3-column configuration. It checks each read against the arithmetic ordering and packing. A counter that carried on the wrong digit, or a swapped field, would show up as a wrong bank or column at the first wrap.

Ready and response delays are varied so that the address must hold through stalls. A design that advanced without a handshake, or that issued a second read before the response, would be caught there.

Mismatches are injected mid-run and on the final read. These cases catch the following faults:
- a design that still pulsed `done` after a mismatch;
- a design that latched the already-advanced address rather than the failing one;
- a design that dropped the failing read from the count.

A compare-off run with corrupted data, and a stray `start` mid-run, show whether the block wrongly fails or restarts.

// File: rtl/rowhop_pkg.sv
package rowhop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

  function automatic int fld_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rowhop_ctr.sv
// Wrapping index counter: counts 0..CNT-1, flags the final value.
module rowhop_ctr #(
  parameter int CNT = 4,
  parameter int W   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         at_last
);
  localparam logic [W-1:0] LAST = W'(CNT - 1);

  assign at_last = (val == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val <= '0;
    end else if (inc) begin
      val <= at_last ? '0 : val + W'(1);
    end
  end
endmodule

// File: rtl/rowhop_addr_gen.sv
// Bank is the fastest digit, then row, then column.
module rowhop_addr_gen #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           adv,
  output logic [BANK_W-1:0]              bank,
  output logic [ROW_W-1:0]               row,
  output logic [COL_W-1:0]               col,
  output logic [ROW_W+BANK_W+COL_W-1:0]  lin,
  output logic                           all_last
);
  localparam int NDIG = 3;
  localparam int DIG_CNT [NDIG] = '{NUM_BANKS, NUM_ROWS, NUM_COLS};

  logic [NDIG-1:0] last_v;
  logic [NDIG:0]   carry;

  assign carry[0] = adv;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    localparam int DW = (g == 0) ? BANK_W : (g == 1) ? ROW_W : COL_W;
    logic [DW-1:0] v;
    rowhop_ctr #(.CNT(DIG_CNT[g]), .W(DW)) ctr_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .inc    (carry[g]),
      .val    (v),
      .at_last(last_v[g])
    );
    assign carry[g+1] = carry[g] & last_v[g];
  end

  assign bank     = g_dig[0].v;
  assign row      = g_dig[1].v;
  assign col      = g_dig[2].v;
  assign lin      = {row, bank, col};
  assign all_last = &last_v;

  logic unused_top;
  assign unused_top = carry[NDIG];
endmodule

// File: rtl/rowhop_cmp.sv
// Response compare and failure capture.
module rowhop_cmp #(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              chk_en,
  input  logic              rsp_take,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [BANK_W-1:0] fly_bank,
  input  logic [ROW_W-1:0]  fly_row,
  input  logic [COL_W-1:0]  fly_col,
  output logic              mism,
  output logic              fail,
  output logic [BANK_W-1:0] fail_bank,
  output logic [ROW_W-1:0]  fail_row,
  output logic [COL_W-1:0]  fail_col
);
  assign mism = rsp_take && chk_en && (rsp_data != exp_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      fail      <= 1'b0;
      fail_bank <= '0;
      fail_row  <= '0;
      fail_col  <= '0;
    end else if (clr) begin
      fail <= 1'b0;
    end else if (mism) begin
      fail      <= 1'b1;
      fail_bank <= fly_bank;
      fail_row  <= fly_row;
      fail_col  <= fly_col;
    end
  end
endmodule

// File: rtl/rowhop_rd_seq.sv
module rowhop_rd_seq
  import rowhop_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 4,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = fld_w(NUM_BANKS),
  localparam int ROW_W    = fld_w(NUM_ROWS),
  localparam int COL_W    = fld_w(NUM_COLS),
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
  localparam int TOTAL    = NUM_BANKS * NUM_ROWS * NUM_COLS,
  localparam int CNT_W    = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmp_en,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BANK_W-1:0] rd_bank,
  output logic [ROW_W-1:0]  rd_row,
  output logic [COL_W-1:0]  rd_col,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] exp_data,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  rd_count,
  output logic              fail,
  output logic [BANK_W-1:0] fail_bank,
  output logic [ROW_W-1:0]  fail_row,
  output logic [COL_W-1:0]  fail_col
);
  seq_state_t        state;
  logic              go, hs, take, mism, all_last;
  logic              cmp_q, last_q;
  logic [BANK_W-1:0] fly_bank;
  logic [ROW_W-1:0]  fly_row;
  logic [COL_W-1:0]  fly_col;

  assign go       = (state == ST_IDLE) && start;
  assign rd_valid = (state == ST_REQ);
  assign hs       = rd_valid && rd_ready;
  assign take     = (state == ST_WAIT) && rsp_valid;
  assign busy     = (state != ST_IDLE);

  rowhop_addr_gen #(
    .NUM_BANKS(NUM_BANKS), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS),
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) agen_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (go),
    .adv     (hs),
    .bank    (rd_bank),
    .row     (rd_row),
    .col     (rd_col),
    .lin     (rd_addr),
    .all_last(all_last)
  );

  rowhop_cmp #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) cmp_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (go),
    .chk_en   (cmp_q),
    .rsp_take (take),
    .rsp_data (rsp_data),
    .exp_data (exp_data),
    .fly_bank (fly_bank),
    .fly_row  (fly_row),
    .fly_col  (fly_col),
    .mism     (mism),
    .fail     (fail),
    .fail_bank(fail_bank),
    .fail_row (fail_row),
    .fail_col (fail_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      rd_count <= '0;
      cmp_q    <= 1'b0;
      last_q   <= 1'b0;
      fly_bank <= '0;
      fly_row  <= '0;
      fly_col  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_REQ;
            rd_count <= '0;
            cmp_q    <= cmp_en;
          end
        end
        ST_REQ: begin
          if (rd_ready) begin
            state    <= ST_WAIT;
            fly_bank <= rd_bank;
            fly_row  <= rd_row;
            fly_col  <= rd_col;
            last_q   <= all_last;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            rd_count <= rd_count + CNT_W'(1);
            if (mism) begin
              state <= ST_IDLE;
            end else if (last_q) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rowhop_rd_seq_chk.sv
module rowhop_rd_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 4,
  localparam int BANK_W   = rowhop_pkg::fld_w(NUM_BANKS),
  localparam int ROW_W    = rowhop_pkg::fld_w(NUM_ROWS),
  localparam int TOTAL    = NUM_BANKS * NUM_ROWS * NUM_COLS,
  localparam int CNT_W    = $clog2(TOTAL + 1),
  localparam bit MULTI    = (NUM_BANKS * NUM_ROWS) > 1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [BANK_W-1:0] rd_bank,
  input logic [ROW_W-1:0]  rd_row,
  input logic              rsp_valid,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  rd_count
);
  logic                    inflight, have_prev;
  logic [BANK_W+ROW_W-1:0] prev_br;
  logic                    hs;

  assign hs = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight  <= 1'b0;
      have_prev <= 1'b0;
      prev_br   <= '0;
    end else begin
      if (hs) inflight <= 1'b1;
      else if (rsp_valid) inflight <= 1'b0;
      if (!busy) have_prev <= 1'b0;
      else if (hs) begin
        have_prev <= 1'b1;
        prev_br   <= {rd_bank, rd_row};
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_bank) && $stable(rd_row)); // R3
  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !inflight); // R5
  AST_NEW_ROW: assert property (@(posedge clk) disable iff (rst)
    MULTI && hs && have_prev |-> {rd_bank, rd_row} != prev_br); // R10
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_count <= CNT_W'(TOTAL)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !fail ##1 !done); // R7
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> !busy && !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_valid); // R1
endmodule

bind rowhop_rd_seq rowhop_rd_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_bank  (rd_bank),
  .rd_row   (rd_row),
  .rsp_valid(rsp_valid),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .rd_count (rd_count)
);

// File: tb/rowhop_rd_seq_tb.sv
module rowhop_rd_seq_tb_top;
  localparam int NB = 2, NR = 4, NC = 3, DW = 16;
  localparam int BW = 1, RW = 2, CW = 2;
  localparam int TOTAL = NB * NR * NC;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cmp_en = 1'b0;
  logic rd_ready = 1'b0, rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0, exp_data = '0;
  logic rd_valid, busy, done, fail;
  logic [BW-1:0] rd_bank, fail_bank;
  logic [RW-1:0] rd_row, fail_row;
  logic [CW-1:0] rd_col, fail_col;
  logic [RW+BW+CW-1:0] rd_addr;
  logic [4:0] rd_count;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  rowhop_rd_seq #(.NUM_BANKS(NB), .NUM_ROWS(NR), .NUM_COLS(NC), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cmp_en(cmp_en),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .exp_data(exp_data),
    .busy(busy), .done(done), .rd_count(rd_count),
    .fail(fail), .fail_bank(fail_bank), .fail_row(fail_row), .fail_col(fail_col)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit cmp, input int bad_idx, input bit stall, input bit poke);
    int prev_br = -1;
    start = 1'b1; cmp_en = cmp;
    @(negedge clk);
    start = 1'b0;
    if (!cmp) cmp_en = 1'b1;                      // R9: late change must not matter
    chk(fail == 1'b0 && busy == 1'b1, "R11", {30'd0, fail, busy}, 1);
    for (int i = 0; i < TOTAL; i++) begin
      int eb = i % NB;
      int er = (i / NB) % NR;
      int ec = i / (NB * NR);
      int ea = (er << (BW + CW)) | (eb << CW) | ec;
      int pat = (16'h5A00 + i * 7) & 16'hFFFF;
      int cur;
      chk(rd_valid == 1'b1, "R5", rd_valid, 1);
      chk(int'(rd_bank) == eb, "R2", rd_bank, eb);
      chk(int'(rd_row) == er, "R2", rd_row, er);
      chk(int'(rd_col) == ec, "R2", rd_col, ec);
      chk(int'(rd_addr) == ea, "R4", rd_addr, ea);
      cur = int'(rd_bank) * NR + int'(rd_row);
      if (prev_br >= 0) chk(cur != prev_br, "R10", cur, prev_br);
      prev_br = cur;
      exp_data = pat[DW-1:0];
      if (stall) begin
        for (int k = 0; k < i % 3; k++) begin
          if (poke && i == 5 && k == 0) start = 1'b1;  // R11: ignored while busy
          @(negedge clk);
          start = 1'b0;
        end
        if (i % 3 > 0) begin
          chk(rd_valid == 1'b1, "R3", rd_valid, 1);
          chk(int'(rd_addr) == ea, "R3", rd_addr, ea);
          if (poke && i == 5) chk(int'(rd_addr) == ea, "R11", rd_addr, ea);
        end
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk(rd_valid == 1'b0, "R5", rd_valid, 0);
      if (stall) repeat (i % 2) begin
        @(negedge clk);
        chk(rd_valid == 1'b0, "R5", rd_valid, 0);
      end
      rsp_valid = 1'b1;
      if (!cmp) rsp_data = pat[DW-1:0] ^ 16'h0F0F;
      else rsp_data = (i == bad_idx) ? ~pat[DW-1:0] : pat[DW-1:0];
      @(negedge clk);
      rsp_valid = 1'b0;
      chk(int'(rd_count) == i + 1, "R6", rd_count, i + 1);
      if (i == bad_idx) begin
        chk(fail == 1'b1, "R8", fail, 1);
        chk(int'(fail_bank) == eb, "R8", fail_bank, eb);
        chk(int'(fail_row) == er, "R8", fail_row, er);
        chk(int'(fail_col) == ec, "R8", fail_col, ec);
        chk(busy == 1'b0 && done == 1'b0, "R8", {30'd0, busy, done}, 0);
        @(negedge clk);
        chk(rd_valid == 1'b0 && done == 1'b0, "R8", {30'd0, rd_valid, done}, 0);
        return;
      end
      if (i == TOTAL - 1) begin
        chk(done == 1'b1, "R7", done, 1);
        chk(busy == 1'b0, "R7", busy, 0);
        chk(fail == 1'b0, cmp ? "R8" : "R9", fail, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", done, 0);
        chk(rd_valid == 1'b0, "R7", rd_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(done == 1'b0, "R1", done, 0);
    chk(fail == 1'b0, "R1", fail, 0);
    chk(rd_count == 5'd0, "R1", rd_count, 0);
    run_seq(1'b1, -1, 1'b0, 1'b0);          // clean pass, no stalls
    run_seq(1'b0, -1, 1'b1, 1'b1);          // compare off, garbage data, stalls, stray start
    run_seq(1'b1, 9, 1'b1, 1'b0);           // mismatch mid-run
    run_seq(1'b1, -1, 1'b0, 1'b0);          // restart after fail
    run_seq(1'b1, TOTAL - 1, 1'b0, 1'b0);   // mismatch on the final read
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule